// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block turns host register writes into command frames on a three-wire serial EEPROM bus. The device holds 256 words of 16 bits. The host programs a 16-bit control word that carries a 2-bit opcode and an 8-bit word address. It uses a 16-bit data register in both directions: it loads the register before a write, and it picks up returned data from the same register after a read. While a command runs, the busy bit in the control word reads as 1. The host polls that bit before it issues the next command.

Every frame begins with a start bit. The opcode and the address follow, most significant bit first. A write frame then carries sixteen data bits. A read frame clocks in one dummy bit and then sixteen data bits from the device. Some commands change the device contents: word write, word erase, fill-all and clear-all. After any of these, the sequencer raises select and waits for the device to report that it is ready, or for a timeout to expire. It then sends a write-disable frame on its own. The host must therefore send write-enable before every such command.

The serial clock is the system clock divided by `CLK_DIV`. The data line changes on the falling serial-clock edge, and the device samples it on the rising edge. Between any two frames, select stays low for at least one serial-clock period.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: After reset, `ctrl_rdata` and `data_rdata` read 0x0000, and `mem_cs`, `mem_sclk` and `mem_mosi` are low.
- R2: A `ctrl_wr` while idle is accepted on that clock edge. From the next cycle, bit 15 of `ctrl_rdata` (busy) reads 1, and bits 9..8 (opcode) and 7..0 (address) read back the written fields.
- R3: While busy is 1, a `ctrl_wr` or a `data_wr` has no effect: the control fields and the data register keep their values.
- R4: Each frame sends, MSB first, a start bit of 1, the opcode, then the address. `mem_mosi` changes only while `mem_sclk` is low.
- R5: Opcode 01 writes one word. The 16 bits of the data register follow the address in the frame, MSB first, for 27 clocked bits in total.
- R6: Opcode 10 reads one word. After the 11 header bits, one dummy bit and then 16 data bits are clocked in, MSB first, for 28 bits in total. The 16 data bits are placed in the data register.
- R7: Opcode 11 erases one word with an 11-bit frame and no data.
- R8: Under opcode 00, address bits 7..6 select a sub-command: 00 disables writes, 01 fills every word from the data register (27-bit frame), 10 clears every word (11-bit frame), 11 enables writes.
- R9: After a word write, a word erase, a fill-all or a clear-all, the sequencer sends a write-disable frame (header 1,00,00xxxxxx). It sends none after a read, an enable or a disable.
- R10: After a modifying frame, select goes high and `mem_miso` is sampled once per serial period. The wait ends at the first sample of 1 or after `POLL_MAX` periods, whichever comes first.
- R11: Select is low for at least `CLK_DIV` system clocks between frames, and `mem_sclk` stays low whenever select is low.
- R12: For a frame of N clocked bits and no poll, busy lasts (N+1)·`CLK_DIV` cycles. For a modifying command it lasts (N+1+P+1+12)·`CLK_DIV` cycles, where P is the number of poll periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word: opcode 9..8, address 7..0 |
| ctrl_rdata | output | 16 | Busy in bit 15, zeros in 14..10, opcode 9..8, address 7..0 |
| data_wr | input | 1 | Write strobe for the data register |
| data_wdata | input | 16 | Data for a write or a fill-all |
| data_rdata | output | 16 | Data register contents (read result) |
| mem_cs | output | 1 | Serial device select, active high |
| mem_sclk | output | 1 | Serial clock |
| mem_mosi | output | 1 | Serial data to the device |
| mem_miso | input | 1 | Serial data and ready status from the device |

## Verification
Some rules can be checked on every cycle without knowing what the device holds, and the assertions check these. Busy rises after an accepted command. Control fields stay put when a command is written while busy. Select is asserted only while busy. The serial clock is idle whenever select is low. The data line holds steady through each high phase of the clock. Every inter-frame gap lasts at least one serial period. Other behaviour shows up only through a device model in the bench's scenarios: bit order and payload alignment, the dummy bit on reads, whether the automatic write-disable actually protects the device, and the exact busy lengths for a ready device and for a poll timeout.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef enum logic [1:0] {
    OP_SUB   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } ee_op_e;

  typedef enum logic [1:0] {
    SUB_WDIS = 2'b00,
    SUB_FILL = 2'b01,
    SUB_CLR  = 2'b10,
    SUB_WEN  = 2'b11
  } ee_sub_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_POLL
  } seq_state_e;

endpackage

// File: rtl/eeprom_sk_div.sv
// Serial clock phase generator: one period is DIV system clocks.
module eeprom_sk_div #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_hi,
  output logic tick_end
);
  localparam int CW = $clog2(DIV);
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run || cnt_q == LAST) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign phase_hi = run && (cnt_q >= MID);
  assign tick_end = run && (cnt_q == LAST);
endmodule

// File: rtl/eeprom_frame_shift.sv
// Parallel-load transmit shifter plus receive shifter, MSB first.
module eeprom_frame_shift #(
  parameter int FRAME_W = 28,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_val,
  input  logic               shift_en,
  input  logic               ser_in,
  output logic               ser_out,
  output logic [DATA_W-1:0]  rx_word
);
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0]  rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load) begin
      tx_d = load_val;
    end else if (shift_en) begin
      tx_d = {tx_q[FRAME_W-2:0], 1'b0};
      rx_d = {rx_q[DATA_W-2:0], ser_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load || shift_en) tx_q <= tx_d;
      if (shift_en)         rx_q <= rx_d;
    end
  end

  assign ser_out = tx_q[FRAME_W-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/eeprom_poll_timer.sv
// Counts serial periods spent waiting for the device to become ready.
module eeprom_poll_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic expired
);
  localparam int PW = $clog2(LIMIT + 1);
  localparam logic [PW-1:0] LAST = PW'(LIMIT - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == LAST);
endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
  import eeprom_seq_pkg::*;
#(
  parameter int CLK_DIV  = 64,
  parameter int POLL_MAX = 4096,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic [15:0] ctrl_wdata,
  output logic [15:0] ctrl_rdata,
  input  logic        data_wr,
  input  logic [15:0] data_wdata,
  output logic [15:0] data_rdata,
  output logic        mem_cs,
  output logic        mem_sclk,
  output logic        mem_mosi,
  input  logic        mem_miso
);
  localparam int OP_W    = 2;
  localparam int HDR_W   = 1 + OP_W + ADDR_W;
  localparam int FRAME_W = HDR_W + 1 + DATA_W;
  localparam int PAD_W   = FRAME_W - HDR_W;
  localparam int RSV_W   = 16 - 1 - OP_W - ADDR_W;
  localparam int BCW     = $clog2(FRAME_W + 1);
  localparam logic [BCW-1:0] NB_HDR = BCW'(HDR_W);
  localparam logic [BCW-1:0] NB_WR  = BCW'(HDR_W + DATA_W);
  localparam logic [BCW-1:0] NB_RD  = BCW'(FRAME_W);

  seq_state_e          state_q, state_d;
  ee_op_e              op_q, op_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0]   data_q, data_d;
  logic [BCW-1:0]      nbits_q, nbits_d;
  logic [BCW-1:0]      bitcnt_q, bitcnt_d;
  logic                poll_q, poll_d;
  logic                wd_q, wd_d;
  logic                rd_q, rd_d;

  logic                load;
  logic [FRAME_W-1:0]  load_val;
  logic                phase_hi, tick;
  logic                ser_out;
  logic [DATA_W-1:0]   rx_word;
  logic                poll_expired;

  ee_op_e              new_op;
  ee_sub_e             new_sub;
  logic [ADDR_W-1:0]   new_addr;
  logic [HDR_W-1:0]    new_hdr;
  logic [FRAME_W-1:0]  hdr_frame, data_frame, wdis_frame;
  logic                ctrl_unused;

  assign ctrl_unused = ^ctrl_wdata[15:ADDR_W+OP_W];

  assign new_op     = ee_op_e'(ctrl_wdata[ADDR_W +: OP_W]);
  assign new_addr   = ctrl_wdata[ADDR_W-1:0];
  assign new_sub    = ee_sub_e'(new_addr[ADDR_W-1 -: 2]);
  assign new_hdr    = {1'b1, new_op, new_addr};
  assign hdr_frame  = {new_hdr, {PAD_W{1'b0}}};
  assign data_frame = {new_hdr, data_q, 1'b0};
  assign wdis_frame = {1'b1, OP_SUB, SUB_WDIS, {(ADDR_W-2){1'b0}}, {PAD_W{1'b0}}};

  eeprom_sk_div #(.DIV(CLK_DIV)) div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state_q != ST_IDLE),
    .phase_hi (phase_hi),
    .tick_end (tick)
  );

  eeprom_frame_shift #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) shf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .shift_en (tick && state_q == ST_SHIFT),
    .ser_in   (mem_miso),
    .ser_out  (ser_out),
    .rx_word  (rx_word)
  );

  eeprom_poll_timer #(.LIMIT(POLL_MAX)) poll_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state_q != ST_POLL),
    .step    (tick),
    .expired (poll_expired)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    addr_d   = addr_q;
    data_d   = data_q;
    nbits_d  = nbits_q;
    bitcnt_d = bitcnt_q;
    poll_d   = poll_q;
    wd_d     = wd_q;
    rd_d     = rd_q;
    load     = 1'b0;
    load_val = hdr_frame;
    unique case (state_q)
      ST_IDLE: begin
        if (data_wr) data_d = data_wdata;
        if (ctrl_wr) begin
          state_d  = ST_SHIFT;
          op_d     = new_op;
          addr_d   = new_addr;
          bitcnt_d = '0;
          load     = 1'b1;
          nbits_d  = NB_HDR;
          rd_d     = 1'b0;
          poll_d   = 1'b0;
          unique case (new_op)
            OP_WRITE: begin
              load_val = data_frame;
              nbits_d  = NB_WR;
              poll_d   = 1'b1;
            end
            OP_READ: begin
              nbits_d = NB_RD;
              rd_d    = 1'b1;
            end
            OP_ERASE: poll_d = 1'b1;
            OP_SUB: begin
              if (new_sub == SUB_FILL) begin
                load_val = data_frame;
                nbits_d  = NB_WR;
              end
              poll_d = (new_sub == SUB_FILL) || (new_sub == SUB_CLR);
            end
          endcase
          wd_d = poll_d;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          bitcnt_d = bitcnt_q + 1'b1;
          if (bitcnt_q == nbits_q - 1'b1) state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (rd_q) begin
          data_d = rx_word;
          rd_d   = 1'b0;
        end
        if (tick) begin
          if (poll_q) begin
            state_d = ST_POLL;
            poll_d  = 1'b0;
          end else if (wd_q) begin
            state_d  = ST_SHIFT;
            load     = 1'b1;
            load_val = wdis_frame;
            nbits_d  = NB_HDR;
            bitcnt_d = '0;
            wd_d     = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_POLL: begin
        if (tick && (mem_miso || poll_expired)) state_d = ST_GAP;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_SUB;
      addr_q   <= '0;
      data_q   <= '0;
      nbits_q  <= '0;
      bitcnt_q <= '0;
      poll_q   <= 1'b0;
      wd_q     <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      poll_q   <= poll_d;
      wd_q     <= wd_d;
      rd_q     <= rd_d;
      if (load) nbits_q <= nbits_d;
      if (state_q == ST_IDLE && ctrl_wr) begin
        op_q   <= op_d;
        addr_q <= addr_d;
      end
      if (data_d != data_q) data_q <= data_d;
    end
  end

  assign ctrl_rdata = {(state_q != ST_IDLE), {RSV_W{1'b0}}, op_q, addr_q};
  assign data_rdata = data_q;
  assign mem_cs     = (state_q == ST_SHIFT) || (state_q == ST_POLL);
  assign mem_sclk   = (state_q == ST_SHIFT) && phase_hi;
  assign mem_mosi   = (state_q == ST_SHIFT) && ser_out;
endmodule

// File: rtl/eeprom_cmd_seq_chk.sv
module eeprom_cmd_seq_chk #(
  parameter int CLK_DIV = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_wr,
  input logic [15:0] ctrl_rdata,
  input logic        mem_cs,
  input logic        mem_sclk,
  input logic        mem_mosi
);
  localparam int LW = $clog2(CLK_DIV + 1);
  localparam logic [LW-1:0] GAP_MIN = LW'(CLK_DIV);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_cnt <= GAP_MIN;
    else if (mem_cs)            low_cnt <= '0;
    else if (low_cnt < GAP_MIN) low_cnt <= low_cnt + 1'b1;
  end

  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_rdata[15]) |=> ctrl_rdata[15]);

  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_rdata[15]) |=> $stable(ctrl_rdata[14:0]));

  // R2
  cs_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs |-> ctrl_rdata[15]);

  // R11
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs |-> !mem_sclk);

  // R11
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs) |-> (low_cnt >= GAP_MIN));

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sclk && $past(mem_sclk)) |-> $stable(mem_mosi));
endmodule

bind eeprom_cmd_seq eeprom_cmd_seq_chk #(.CLK_DIV(CLK_DIV)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_wr    (ctrl_wr),
  .ctrl_rdata (ctrl_rdata),
  .mem_cs     (mem_cs),
  .mem_sclk   (mem_sclk),
  .mem_mosi   (mem_mosi)
);

// File: tb/eeprom_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module eeprom_cmd_seq_tb_top;
  localparam int DIV  = 4;
  localparam int PMAX = 16;
  localparam int BUSY_CYC = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_wr;
  logic [15:0] ctrl_wdata;
  logic [15:0] ctrl_rdata;
  logic        data_wr;
  logic [15:0] data_wdata;
  logic [15:0] data_rdata;
  logic        mem_cs, mem_sclk, mem_mosi;
  logic        mem_miso;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  eeprom_cmd_seq #(.CLK_DIV(DIV), .POLL_MAX(PMAX)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .data_rdata(data_rdata),
    .mem_cs(mem_cs), .mem_sclk(mem_sclk), .mem_mosi(mem_mosi), .mem_miso(mem_miso)
  );

  // Behavioural serial device
  logic [15:0] mem [256];
  logic        wen;
  logic        stuck;
  int          wd_cnt;
  logic [10:0] last_hdr;
  logic [26:0] sh;
  int          bc;
  int          busy_cnt;
  logic        rd_act;
  logic [15:0] rd_word;
  logic        psk, pcs;
  logic [10:0] hdr;
  logic [15:0] wdat;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
      wen = 1'b0; wd_cnt = 0; last_hdr = '0; sh = '0; bc = 0;
      busy_cnt = 0; rd_act = 1'b0; rd_word = '0; psk = 1'b0; pcs = 1'b0;
      mem_miso <= 1'b1;
    end else begin
      if (mem_cs && !pcs) begin bc = 0; sh = '0; rd_act = 1'b0; end
      if (mem_cs && mem_sclk && !psk) begin
        sh = {sh[25:0], mem_mosi};
        bc++;
        if (bc == 11 && sh[10] && sh[9:8] == 2'b10) begin
          rd_act = 1'b1; rd_word = mem[sh[7:0]];
        end
        if (rd_act && bc == 12) mem_miso <= 1'b0;
        else if (rd_act && bc >= 13 && bc <= 28) mem_miso <= rd_word[28-bc];
      end
      if (!mem_cs && pcs) begin
        rd_act = 1'b0;
        if (bc == 11 || bc == 27) begin
          hdr  = (bc == 11) ? sh[10:0] : sh[26:16];
          wdat = sh[15:0];
          last_hdr = hdr;
          if (hdr[10]) begin
            case (hdr[9:8])
              2'b01: if (bc == 27 && wen) begin mem[hdr[7:0]] = wdat; busy_cnt = BUSY_CYC; end
              2'b11: if (wen) begin mem[hdr[7:0]] = 16'hFFFF; busy_cnt = BUSY_CYC; end
              2'b00: begin
                case (hdr[7:6])
                  2'b00: begin wen = 1'b0; wd_cnt++; end
                  2'b11: wen = 1'b1;
                  2'b01: if (bc == 27 && wen) begin
                    for (int i = 0; i < 256; i++) mem[i] = wdat;
                    busy_cnt = BUSY_CYC;
                  end
                  default: if (wen) begin
                    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
                    busy_cnt = BUSY_CYC;
                  end
                endcase
              end
              default: ;
            endcase
          end
        end
      end
      if (busy_cnt != 0) busy_cnt--;
      if (!rd_act) mem_miso <= !(busy_cnt != 0 || stuck);
      psk = mem_sclk;
      pcs = mem_cs;
    end
  end

  function automatic logic [15:0] pat(input int a);
    logic [7:0] b = a[7:0];
    return {b, ~b} ^ 16'h3C5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] a);
    @(negedge clk);
    ctrl_wdata = {6'b0, op, a};
    ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (ctrl_rdata[15]) begin cyc++; @(negedge clk); end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] a, output int cyc);
    issue(op, a);
    wait_idle(cyc);
  endtask

  task automatic load_data(input logic [15:0] v);
    @(negedge clk);
    data_wdata = v; data_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    int wdb;
    rst_n = 1'b0; ctrl_wr = 1'b0; ctrl_wdata = '0; data_wr = 1'b0; data_wdata = '0; stuck = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ctrl_rdata == 16'h0000, "R1 ctrl", ctrl_rdata, 0);
    chk(data_rdata == 16'h0000, "R1 data", data_rdata, 0);
    chk({mem_cs, mem_sclk, mem_mosi} == 3'b000, "R1 pins", {mem_cs, mem_sclk, mem_mosi}, 0);

    // R8 enable sub-command, R12 length, R4 header, R9 no auto-disable
    wdb = wd_cnt;
    cmd(2'b00, 8'hC0, cyc);
    chk(cyc == 12*DIV, "R12 enable busy", cyc, 12*DIV);
    chk(wen == 1'b1, "R8 enable", wen, 1);
    chk(last_hdr == 11'b1_00_11000000, "R4 header", last_hdr, 11'b1_00_11000000);
    chk(wd_cnt == wdb, "R9 none after enable", wd_cnt, wdb);

    // R5 write sweep, R9 auto-disable each time
    for (int a = 0; a < 256; a++) begin
      load_data(pat(a));
      cmd(2'b00, 8'hC0, cyc);
      cmd(2'b01, a[7:0], cyc);
      chk(wen == 1'b0, "R9 auto disable", wen, 0);
    end

    // R6 read sweep, R2 fields, R12 read length
    for (int a = 0; a < 256; a++) begin
      wdb = wd_cnt;
      cmd(2'b10, a[7:0], cyc);
      chk(data_rdata == pat(a), "R5 R6 readback", data_rdata, pat(a));
      if (a == 0 || a == 255) begin
        chk(cyc == 29*DIV, "R12 read busy", cyc, 29*DIV);
        chk(ctrl_rdata == {8'h02, a[7:0]}, "R2 fields", ctrl_rdata, {8'h02, a[7:0]});
        chk(wd_cnt == wdb, "R9 none after read", wd_cnt, wdb);
      end
    end

    // R10 ready at first poll: write with device protected
    load_data(16'hDEAD);
    cmd(2'b01, 8'd5, cyc);
    chk(cyc == 42*DIV, "R10 R12 ready poll", cyc, 42*DIV);
    cmd(2'b10, 8'd5, cyc);
    chk(data_rdata == pat(5), "R9 protected write", data_rdata, pat(5));

    // R7 erase
    cmd(2'b00, 8'hC0, cyc);
    cmd(2'b11, 8'd7, cyc);
    cmd(2'b10, 8'd7, cyc);
    chk(data_rdata == 16'hFFFF, "R7 erase", data_rdata, 16'hFFFF);
    cmd(2'b11, 8'd8, cyc);
    cmd(2'b10, 8'd8, cyc);
    chk(data_rdata == pat(8), "R9 protected erase", data_rdata, pat(8));

    // R8 disable sub-command
    cmd(2'b00, 8'hC0, cyc);
    cmd(2'b00, 8'h00, cyc);
    load_data(16'h0BAD);
    cmd(2'b01, 8'd9, cyc);
    cmd(2'b10, 8'd9, cyc);
    chk(data_rdata == pat(9), "R8 disable", data_rdata, pat(9));

    // R3 control write while busy
    issue(2'b10, 8'd10);
    repeat (5) @(negedge clk);
    ctrl_wdata = {6'b0, 2'b11, 8'd11}; ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    wait_idle(cyc);
    chk(ctrl_rdata[9:0] == {2'b10, 8'd10}, "R3 ctrl ignored", ctrl_rdata[9:0], {2'b10, 8'd10});
    chk(data_rdata == pat(10), "R3 read intact", data_rdata, pat(10));

    // R3 data write while busy
    load_data(16'h7777);
    issue(2'b00, 8'h00);
    repeat (3) @(negedge clk);
    data_wdata = 16'hBEEF; data_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
    wait_idle(cyc);
    chk(data_rdata == 16'h7777, "R3 data ignored", data_rdata, 16'h7777);

    // R8 fill-all and clear-all
    load_data(16'h1234);
    cmd(2'b00, 8'hC0, cyc);
    cmd(2'b00, 8'h40, cyc);
    chk(wen == 1'b0, "R9 after fill", wen, 0);
    cmd(2'b10, 8'd0, cyc);
    chk(data_rdata == 16'h1234, "R8 fill lo", data_rdata, 16'h1234);
    cmd(2'b10, 8'd200, cyc);
    chk(data_rdata == 16'h1234, "R8 fill hi", data_rdata, 16'h1234);
    cmd(2'b00, 8'hC0, cyc);
    cmd(2'b00, 8'h80, cyc);
    chk(wen == 1'b0, "R9 after clear", wen, 0);
    cmd(2'b10, 8'd3, cyc);
    chk(data_rdata == 16'hFFFF, "R8 clear", data_rdata, 16'hFFFF);

    // R10 poll timeout
    stuck = 1'b1;
    load_data(16'h5555);
    cmd(2'b00, 8'hC0, cyc);
    cmd(2'b01, 8'd20, cyc);
    chk(cyc == (41+PMAX)*DIV, "R10 timeout", cyc, (41+PMAX)*DIV);
    chk(wen == 1'b0, "R9 after timeout", wen, 0);
    stuck = 1'b0;
    repeat (BUSY_CYC) @(negedge clk);
    cmd(2'b10, 8'd20, cyc);
    chk(data_rdata == 16'h5555, "R5 write after timeout", data_rdata, 16'h5555);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule